// File: doc/BRIEF.md
# Early-Terminating Shift-and-Add Multiplier

This block multiplies two unsigned 16-bit operands one bit per clock, using radix-2 shift-and-add with a right-shifting accumulator. It does not always run a fixed 16 steps. When a request is accepted, a priority encoder finds the most significant position of each operand: the index of its highest set bit, counting the least significant bit as 1, and 0 for a zero operand. The operand with the smaller position becomes the multiplier and the other becomes the multiplicand. Only as many add/shift steps run as the multiplier's position. The steps that are skipped would only have added zero.

The skipped steps also skip their shifts, so the accumulator ends up misaligned. A single logical right shift corrects it, and the shift amount is the number of steps that were omitted. The inputs of this correction shifter are held at zero until the last step has finished. They therefore do not toggle while the accumulator is working.

A client pulses `start` with both operands valid. The block pulses `done` once when the 32-bit product is ready. Small operands complete in proportionally fewer cycles.

Top module: `seqSkipMul`

## Requirements
- R1: When `done` is high, `product` equals the unsigned product `opA * opB` of the operands presented with the accepted `start`.
- R2: `done` is high for exactly one cycle per accepted request. `product` changes only in the cycle where `done` is high, and otherwise holds its value until the next result.
- R3: Let the position of a value be the index of its highest 1 bit, with bit 0 counting as position 1 and zero having position 0. Let N be the smaller of the two operand positions. Then `done` is high in the cycle after the (N+1)-th rising clock edge that follows the edge which accepted `start`.
- R4: If either operand is zero, N is 0 and the result is 0. `done` is high after the first edge that follows acceptance.
- R5: `start` is ignored, together with the operands presented alongside it, from the edge after acceptance through the edge that raises `done`. Neither the pending result nor its timing is affected.
- R6: While `rstN` is low, `done` and `product` are 0, and they remain 0 until a request completes.
- R7: Swapping `opA` and `opB` gives the same product and the same latency. The operand with the smaller position always acts as the multiplier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, sampled only when idle |
| opA | input | 16 | First unsigned operand |
| opB | input | 16 | Second unsigned operand |
| product | output | 32 | Unsigned product, held between results |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is a second `start` that arrives while a short, early-terminated request is still running, including one that lands on the very edge where `done` rises. A queued request must not disturb the result, and a request made in the `done` cycle must be taken. The stimulus issues back-to-back requests with operands of a chosen bit width, so that N spans 0 to 16. It keeps `start` high with different operands throughout the run and on the completion cycle, and checks latency and product against a cycle-level model on every clock.

// File: rtl/seqSkipMulPkg.sv
package seqSkipMulPkg;

  typedef struct packed {
    logic load;
    logic step;
    logic fix;
  } dpStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } ctrlStateT;

endpackage

// File: rtl/mspEncoder.sv
module mspEncoder #(
  parameter int WIDTH = 16,
  localparam int POS_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] value,
  output logic [POS_W-1:0] pos
);

  // Priority encoder: the highest set bit wins; an all-zero input gives 0.
  always_comb begin
    pos = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (value[i]) pos = POS_W'(i + 1);
    end
  end

endmodule

// File: rtl/seqSkipMulCtrl.sv
module seqSkipMulCtrl
  import seqSkipMulPkg::*;
#(
  parameter int WIDTH = 16,
  localparam int POS_W = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [POS_W-1:0] minPos,
  output dpStrobeT         strobe,
  output logic             done
);

  ctrlStateT        state, stateNext;
  logic [POS_W-1:0] remaining;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          stateNext   = (minPos == '0) ? ST_FIX : ST_RUN;
        end
      end
      ST_RUN: begin
        strobe.step = 1'b1;
        if (remaining == POS_W'(1)) stateNext = ST_FIX;
      end
      ST_FIX: begin
        strobe.fix = 1'b1;
        stateNext  = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      remaining <= '0;
      done      <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobe.fix;
      if (strobe.load)      remaining <= minPos;
      else if (strobe.step) remaining <= remaining - POS_W'(1);
    end
  end

endmodule

// File: rtl/seqSkipMulDp.sv
module seqSkipMulDp
  import seqSkipMulPkg::*;
#(
  parameter int WIDTH = 16,
  localparam int POS_W = $clog2(WIDTH + 1),
  localparam int PW = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobeT         strobe,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [POS_W-1:0] minPos,
  output logic [PW-1:0]    product
);

  logic [POS_W-1:0] posA, posB, stepsDone, shiftAmt;
  logic             swapOps;
  logic [WIDTH-1:0] mlrSel, mcandSel, mcand, addend;
  logic [PW-1:0]    acc, gatedIn, shifted;
  logic [WIDTH:0]   stepSum;
  logic [POS_W-1:0] gatedAmt;

  mspEncoder #(.WIDTH(WIDTH)) u_encA (.value(opA), .pos(posA));
  mspEncoder #(.WIDTH(WIDTH)) u_encB (.value(opB), .pos(posB));

  // The operand with fewer meaningful bits drives the step count.
  assign swapOps  = posB < posA;
  assign mlrSel   = swapOps ? opB : opA;
  assign mcandSel = swapOps ? opA : opB;
  assign minPos   = swapOps ? posB : posA;

  assign addend  = acc[0] ? mcand : '0;
  assign stepSum = {1'b0, acc[PW-1:WIDTH]} + {1'b0, addend};

  // Shifter inputs stay zero except in the correction cycle.
  assign shiftAmt = POS_W'(WIDTH) - stepsDone;
  assign gatedIn  = strobe.fix ? acc : '0;
  assign gatedAmt = strobe.fix ? shiftAmt : '0;
  assign shifted  = gatedIn >> gatedAmt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcand     <= '0;
      acc       <= '0;
      stepsDone <= '0;
      product   <= '0;
    end else begin
      if (strobe.load) begin
        mcand     <= mcandSel;
        acc       <= {{WIDTH{1'b0}}, mlrSel};
        stepsDone <= minPos;
      end else if (strobe.step) begin
        acc <= {stepSum, acc[WIDTH-1:1]};
      end
      if (strobe.fix) product <= shifted;
    end
  end

endmodule

// File: rtl/seqSkipMul.sv
module seqSkipMul
  import seqSkipMulPkg::*;
#(
  parameter int WIDTH = 16,
  localparam int POS_W = $clog2(WIDTH + 1),
  localparam int PW = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [PW-1:0]    product,
  output logic             done
);

  dpStrobeT         strobe;
  logic [POS_W-1:0] minPos;

  seqSkipMulCtrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .minPos(minPos),
    .strobe(strobe), .done(done)
  );

  seqSkipMulDp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opA(opA), .opB(opB),
    .minPos(minPos), .product(product)
  );

endmodule

// File: rtl/seqSkipMulChk.sv
module seqSkipMulChk #(
  parameter int WIDTH = 16,
  localparam int PW = 2 * WIDTH
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [PW-1:0]    product,
  input logic             done
);

  logic          inFlight, expZero, accept;
  logic [PW-1:0] expProd;
  logic [7:0]    expSteps, elapsed;

  function automatic logic [7:0] topBit(input logic [WIDTH-1:0] v);
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (v[i]) return 8'(i + 1);
    end
    return 8'd0;
  endfunction

  assign accept = start && (!inFlight || done);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFlight <= 1'b0;
      expZero  <= 1'b0;
      expProd  <= '0;
      expSteps <= '0;
      elapsed  <= '0;
    end else if (accept) begin
      inFlight <= 1'b1;
      expZero  <= (opA == '0) || (opB == '0);
      expProd  <= PW'(opA) * PW'(opB);
      expSteps <= (topBit(opA) < topBit(opB)) ? topBit(opA) : topBit(opB);
      elapsed  <= '0;
    end else begin
      if (done) inFlight <= 1'b0;
      else if (inFlight) elapsed <= elapsed + 8'd1;
    end
  end

  assert_product_value_R1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> product == expProd);

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_product_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(product));

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> elapsed == expSteps + 8'd1);

  assert_zero_operand_R4: assert property (@(posedge clk) disable iff (!rstN)
    (done && expZero) |-> (product == '0 && expSteps == 8'd0));

  assert_done_needs_request_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> inFlight);

  assert_reset_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!done && product == '0));

endmodule

bind seqSkipMul seqSkipMulChk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/seqSkipMul_tb.sv
module seqSkipMul_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic [31:0] product;
  logic        done;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // Reference model state
  bit          mBusy = 0;
  int          mCnt = 0;
  logic [31:0] mPend = '0;
  logic [31:0] mProd = '0;
  logic        mDone = 1'b0;

  always #5 clk = ~clk;

  seqSkipMul u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opA(opA), .opB(opB),
    .product(product), .done(done)
  );

  function automatic int bitLen(input logic [15:0] v);
    int n = 0;
    logic [15:0] t = v;
    while (t != 0) begin
      t = t >> 1;
      n++;
    end
    return n;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Apply inputs for one cycle, advance the model over the coming edge,
  // then compare at the falling edge.
  task automatic tick(input logic s, input logic [15:0] a, input logic [15:0] b, input string tag);
    start = s;
    opA = a;
    opB = b;
    mDone = 1'b0;
    if (mBusy) begin
      if (mCnt == 0) begin
        mDone = 1'b1;
        mProd = mPend;
        mBusy = 0;
      end else begin
        mCnt--;
      end
    end else if (s) begin
      mCnt  = (bitLen(a) < bitLen(b)) ? bitLen(a) : bitLen(b);
      mPend = 32'(a) * 32'(b);
      mBusy = 1;
    end
    @(negedge clk);
    check({tag, " R3 done"}, 32'(done), 32'(mDone));
    check({tag, " R1 product"}, product, mProd);
  endtask

  task automatic runOp(input logic [15:0] a, input logic [15:0] b, input string tag);
    tick(1'b1, a, b, tag);
    while (mBusy) tick(1'b0, 16'h0, 16'h0, tag);
    tick(1'b0, 16'h0, 16'h0, {tag, " R2 hold"});
  endtask

  function automatic logic [15:0] shaped();
    int w = $urandom_range(0, 16);
    logic [31:0] mask = (32'h1 << w) - 32'h1;
    return 16'($urandom() & mask);
  endfunction

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R6 reset done", 32'(done), 32'h0);
    check("R6 reset product", product, 32'h0);
    rstN = 1'b1;
    tick(1'b0, 16'h0, 16'h0, "R6 after reset");

    // R4: zero operands finish after one edge
    runOp(16'h0, 16'h0, "R4 zero-zero");
    runOp(16'h0, 16'hFFFF, "R4 zero-max");
    runOp(16'h1234, 16'h0, "R4 value-zero");

    // Corner values
    runOp(16'h1, 16'h1, "R1 one-one");
    runOp(16'hFFFF, 16'hFFFF, "R1 max-max");
    runOp(16'h1, 16'hFFFF, "R7 one-max");
    runOp(16'hFFFF, 16'h1, "R7 max-one");
    for (int i = 0; i < 16; i++) begin
      runOp(16'h1 << i, 16'hFFFF, "R3 single-bit");
      runOp(16'hFFFF, 16'h1 << (15 - i), "R7 single-bit swapped");
    end

    // R7: both operand orders give the same result and latency
    for (int i = 0; i < 20; i++) begin
      logic [15:0] a = shaped();
      logic [15:0] b = shaped();
      runOp(a, b, "R7 order ab");
      runOp(b, a, "R7 order ba");
    end

    // R5: start held high with other operands while busy; also lands on done cycle
    for (int i = 0; i < 30; i++) begin
      tick(1'b1, shaped(), shaped(), "R5 accept");
      while (mBusy) tick(1'b1, 16'hFFFF, 16'hFFFF, "R5 busy start");
    end
    while (mBusy || mDone) tick(1'b0, 16'h0, 16'h0, "R5 drain");

    // Random back-to-back traffic
    for (int i = 0; i < 300; i++) begin
      runOp(shaped(), shaped(), "R1 random");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule